// File: doc/BRIEF.md
# Transmit-Empty Interrupt Qualifier

This block decides when a UART raises its "transmit holding register empty" interrupt flag. It watches the occupancy of the transmit FIFO, the write strobe into the holding register, reads of the interrupt identification register and a 16x baud tick. It then produces one flag for the interrupt prioritizer. The block exists to stop a burst of empty interrupts while software is still filling the FIFO after start-up.

An empty event is the FIFO reaching zero while the qualifier is waiting for one. If the FIFO held two or more characters at the same time since the previous empty event, the flag rises on the next clock. Otherwise the block waits for one character time without the stop bit before raising the flag, and a write during that wait cancels the flag. The FIFO storage, the serializer and the priority encoding belong to other blocks.

The controller has four states:
- `ST_WAIT_EMPTY`: the FIFO is busy, or the block is waiting for an empty event.
- `ST_DELAY`: a character-time delay is running.
- `ST_RAISED`: the flag is high.
- `ST_SERVED`: the flag was cleared while the FIFO is still empty.

Transitions:
- WAIT_EMPTY→RAISED: empty, and the two-character tracker is set.
- WAIT_EMPTY→DELAY: empty, and the tracker is clear.
- WAIT_EMPTY→SERVED: empty together with a write.
- DELAY→RAISED: the timer expires.
- DELAY→SERVED: a write arrives.
- DELAY→WAIT_EMPTY: the FIFO becomes non-empty.
- RAISED→SERVED: a write, or an identification read while this interrupt is the top one.
- RAISED→WAIT_EMPTY: the FIFO becomes non-empty.
- SERVED→WAIT_EMPTY: the FIFO becomes non-empty.
- Any state→WAIT_EMPTY: the FIFO enable input changes level.

Top module: `thre_qualifier`

## Requirements
- R1: After reset `thre_flag` is low and the state is WAIT_EMPTY. The first empty event after reset takes the delayed path.
- R2: The delay lasts (1 + data bits + parity bit) × 16 baud ticks. Data bits are 5 + `word_len`, with `word_len` encoding 0..3 as 5..8 bits. `parity_en` = 1 adds one bit. The flag rises on the clock edge that takes in the last tick.
- R3: If `fifo_level` was 2 or more at any clock since the previous empty event, the next empty event raises `thre_flag` one clock later.
- R4: Every empty event clears the two-character tracker. A later empty event with at most one character in between takes the delayed path.
- R5: A `thr_wr` pulse drives `thre_flag` low on the next clock.
- R6: An `iir_rd` pulse clears a raised flag only while `thre_top` is 1. With `thre_top` = 0 the read has no effect.
- R7: A `thr_wr` during the delay cancels it. The flag stays low until the FIFO becomes non-empty and empties again.
- R8: Any change of level on `fifo_en` clears the flag and the tracker and returns to WAIT_EMPTY. The following empty event therefore takes the delayed path.
- R9: The delay counter advances only on clocks where `baud_tick` is 1.
- R10: A non-zero `fifo_level` forces `thre_flag` low on the next clock.
- R11: After the flag is cleared with the FIFO still empty, no new flag rises until the FIFO becomes non-empty and then empties again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFO enable bit; any change of level resets the qualifier |
| fifo_level | input | LVL_W (5) | Current transmit FIFO occupancy |
| thr_wr | input | 1 | Write strobe into the transmit holding register |
| iir_rd | input | 1 | Read strobe of the interrupt identification register |
| thre_top | input | 1 | This interrupt is currently the highest pending one |
| word_len | input | 2 | Data length code: 0..3 means 5..8 bits |
| parity_en | input | 1 | Parity bit is present in the frame |
| baud_tick | input | 1 | 16x baud enable pulse |
| thre_flag | output | 1 | Qualified transmit-empty interrupt flag |

## Verification
Assertions check the following on every cycle:
- the write clear;
- the qualified identification-read clear;
- the non-empty drop;
- that a rise always follows an empty FIFO;
- that the counter holds between ticks;
- that the tracker only sets after a level of two.

The exact length of the delay for each frame format, and the choice between the immediate and the delayed path, can only be shown by the bench's scenarios. The same holds for cancelling the delay, for staying quiet after a served flag, and for the effect of toggling the enable.

// File: rtl/thre_qual_pkg.sv
package thre_qual_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_EMPTY = 2'd0,
        ST_DELAY      = 2'd1,
        ST_RAISED     = 2'd2,
        ST_SERVED     = 2'd3
    } thre_state_t;

    localparam int START_BITS = 1;
    localparam int MIN_DATA   = 5;
    localparam int MAX_FRAME  = START_BITS + MIN_DATA + 3 + 1;

endpackage

// File: rtl/thre_pair_tracker.sv
module thre_pair_tracker #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LVL_W-1:0] level,
    output logic             held_two
);

    localparam logic [LVL_W-1:0] PAIR = LVL_W'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_two <= 1'b0;
        end else if (clr) begin
            held_two <= 1'b0;
        end else if (level >= PAIR) begin
            held_two <= 1'b1;
        end
    end

    assert_pair_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held_two) |-> $past(level) >= PAIR);

endmodule

// File: rtl/thre_char_timer.sv
module thre_char_timer
    import thre_qual_pkg::*;
#(
    parameter int OVS   = 16,
    parameter int CNT_W = $clog2(MAX_FRAME * OVS + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic       tick,
    input  logic [1:0] word_len,
    input  logic       parity_en,
    output logic       done
);

    logic [CNT_W-1:0] cnt;
    logic             running;
    logic [CNT_W-1:0] frame_bits;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        frame_bits = CNT_W'(START_BITS + MIN_DATA) + CNT_W'(word_len) + CNT_W'(parity_en);
        load_val   = frame_bits * CNT_W'(OVS);
        done       = running && tick && (cnt == CNT_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (start) begin
            cnt     <= load_val;
            running <= 1'b1;
        end else if (abort) begin
            running <= 1'b0;
        end else if (running && tick) begin
            cnt <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
                running <= 1'b0;
            end
        end
    end

    assert_hold_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        running && !tick && !start && !abort |=> $stable(cnt));

    assert_running_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> cnt != '0);

endmodule

// File: rtl/thre_qualifier.sv
module thre_qualifier
    import thre_qual_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OVS        = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             thr_wr,
    input  logic             iir_rd,
    input  logic             thre_top,
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic             baud_tick,
    output logic             thre_flag
);

    localparam int CNT_W = $clog2(MAX_FRAME * OVS + 1);

    thre_state_t state, nxt;
    logic en_prev;
    logic en_toggle;
    logic empty;
    logic held_two;
    logic trk_clr;
    logic tmr_start;
    logic tmr_abort;
    logic tmr_done;

    assign empty     = (fifo_level == '0);
    assign en_toggle = fifo_en ^ en_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_WAIT_EMPTY;
            en_prev <= 1'b1;
        end else begin
            state   <= nxt;
            en_prev <= fifo_en;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_EMPTY: begin
                if (empty) begin
                    if (thr_wr)        nxt = ST_SERVED;
                    else if (held_two) nxt = ST_RAISED;
                    else               nxt = ST_DELAY;
                end
            end
            ST_DELAY: begin
                if (thr_wr)        nxt = ST_SERVED;
                else if (!empty)   nxt = ST_WAIT_EMPTY;
                else if (tmr_done) nxt = ST_RAISED;
            end
            ST_RAISED: begin
                if (thr_wr || (iir_rd && thre_top)) nxt = ST_SERVED;
                else if (!empty)                    nxt = ST_WAIT_EMPTY;
            end
            ST_SERVED: begin
                if (!empty) nxt = ST_WAIT_EMPTY;
            end
            default: nxt = ST_WAIT_EMPTY;
        endcase
        if (en_toggle) begin
            nxt = ST_WAIT_EMPTY;
        end
    end

    always_comb begin
        thre_flag = (state == ST_RAISED);
        trk_clr   = en_toggle || ((state == ST_WAIT_EMPTY) && empty);
        tmr_start = (state == ST_WAIT_EMPTY) && (nxt == ST_DELAY);
        tmr_abort = (state == ST_DELAY) && (nxt != ST_DELAY);
    end

    thre_pair_tracker #(
        .LVL_W(LVL_W)
    ) u_tracker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (trk_clr),
        .level    (fifo_level),
        .held_two (held_two)
    );

    thre_char_timer #(
        .OVS  (OVS),
        .CNT_W(CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .abort    (tmr_abort),
        .tick     (baud_tick),
        .word_len (word_len),
        .parity_en(parity_en),
        .done     (tmr_done)
    );

    assert_wr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        thr_wr |=> !thre_flag);

    assert_iir_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rd && thre_top && thre_flag |=> !thre_flag);

    assert_busy_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level != '0 |=> !thre_flag);

    assert_rise_after_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(thre_flag) |-> $past(fifo_level) == '0);

    assert_toggle_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        en_toggle |=> !thre_flag && !held_two);

endmodule

// File: tb/thre_qualifier_test.sv
module thre_qualifier_test;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 5;
    localparam int NVEC = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b1;
    logic [LW-1:0] fifo_level = 5'd1;
    logic          thr_wr = 1'b0;
    logic          iir_rd = 1'b0;
    logic          thre_top = 1'b0;
    logic [1:0]    word_len = 2'd3;
    logic          parity_en = 1'b0;
    logic          baud_tick = 1'b0;
    logic          thre_flag;

    int n_cmp = 0;
    int n_bad = 0;

    // {level[4:0], thr_wr, iir_rd, thre_top, expected flag}
    localparam logic [8:0] VEC [NVEC] = '{
        {5'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd2, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {5'd0, 1'b0, 1'b1, 1'b0, 1'b1},
        {5'd0, 1'b0, 1'b1, 1'b1, 1'b0},
        {5'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd2, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {5'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd0, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        {5'd1, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd2, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {5'd2, 1'b0, 1'b0, 1'b0, 1'b0},
        {5'd0, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    // requirement tag for each table row
    localparam string VTAG [NVEC] = '{
        "R10", "R3", "R3", "R3", "R3", "R6", "R6", "R11", "R10", "R4", "R3",
        "R5", "R10", "R4", "R9", "R7", "R7", "R3", "R3", "R10", "R3"
    };

    thre_qualifier uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (fifo_en),
        .fifo_level(fifo_level),
        .thr_wr    (thr_wr),
        .iir_rd    (iir_rd),
        .thre_top  (thre_top),
        .word_len  (word_len),
        .parity_en (parity_en),
        .baud_tick (baud_tick),
        .thre_flag (thre_flag)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp);
        n_cmp++;
        if (thre_flag !== exp) begin
            n_bad++;
            $display("FAIL %s: thre_flag=%b expected=%b at %0t", req, thre_flag, exp, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 3);
        @(negedge clk);
        check("R1", 1'b0);
        // R1/R2: first empty after reset is delayed, 8N1 -> 9*16 = 144 ticks
        fifo_level = 5'd0;
        baud_tick  = 1'b1;
        rst_n      = 1'b1;
        step();
        check("R1", 1'b0);
        repeat (143) step();
        check("R2", 1'b0);
        step();
        check("R2", 1'b1);
        baud_tick = 1'b0;

        // table walk, one clock per row
        for (int i = 0; i < NVEC; i++) begin
            fifo_level = VEC[i][8:4];
            thr_wr     = VEC[i][3];
            iir_rd     = VEC[i][2];
            thre_top   = VEC[i][1];
            step();
            check(VTAG[i], VEC[i][0]);
        end
        thr_wr = 1'b0; iir_rd = 1'b0; thre_top = 1'b0;

        // R8: enable toggle while flag high and tracker had been set
        fifo_level = 5'd0;
        fifo_en    = 1'b0;
        baud_tick  = 1'b1;
        step();
        check("R8", 1'b0);
        step();
        check("R8", 1'b0);
        repeat (143) step();
        check("R8", 1'b0);
        step();
        check("R2", 1'b1);

        // R9 and R2: 5 data bits with parity -> 7*16 = 112 ticks
        baud_tick  = 1'b0;
        fifo_level = 5'd1;
        step();
        check("R10", 1'b0);
        word_len   = 2'd0;
        parity_en  = 1'b1;
        fifo_level = 5'd0;
        step();
        repeat (200) step();
        check("R9", 1'b0);
        baud_tick = 1'b1;
        repeat (111) step();
        check("R2", 1'b0);
        step();
        check("R2", 1'b1);

        // R11: served with FIFO still empty stays quiet
        iir_rd   = 1'b1;
        thre_top = 1'b1;
        step();
        check("R6", 1'b0);
        iir_rd   = 1'b0;
        thre_top = 1'b0;
        repeat (300) step();
        check("R11", 1'b0);

        // R7: write during delay cancels
        fifo_level = 5'd1;
        step();
        fifo_level = 5'd0;
        step();
        repeat (50) step();
        thr_wr = 1'b1;
        step();
        check("R7", 1'b0);
        thr_wr = 1'b0;
        repeat (200) step();
        check("R7", 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule